// File: doc/BRIEF.md
# Descriptor Fetch Sequencer

This block fills a DMA channel's parameter and working registers from a descriptor held in memory. It is used when a channel is started, and again when a chained work unit completes. On a start pulse it captures the seed register values, then decodes the flow-mode and descriptor-size fields of the configuration word. It then reads the descriptor one halfword at a time over a request/response memory port, and places each returned halfword in its parameter register.

Once the last halfword arrives, the working registers are set from the loaded parameters: current descriptor pointer, current address and the two current counters. A one-cycle done pulse marks the update. A start address that does not match the element size raises an alignment flag. An illegal flow/size combination puts the block in an error state. In that state it issues no reads and leaves the working registers as they were. The block moves no data and computes no addresses during a transfer.

Configuration word fields: flow mode in bits [14:12], descriptor size (in halfwords) in bits [11:8], word size in bits [3:2].

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset the block is idle and raises none of `rd_valid_o`, `busy_o`, `done_o`, `cfg_err_o` or `align_err_o`. All register outputs are zero.
- R2: Flow codes 0 (stop) and 1 (autobuffer) with size 0 issue no reads. The block then gives `done_o` two cycles after the start edge.
- R3: Each flow code has a legal size range: codes 0 and 1 take only size 0, code 4 (array) takes 1..7, code 6 (small list) takes 1..8 and code 7 (large list) takes 1..9. Flow codes 2, 3 and 5 are illegal. An illegal code or a size outside its range sets `cfg_err_o` and issues no read. It leaves the current registers unchanged, raises no `done_o`, and the state holds until the next start.
- R4: Array mode reads exactly `size` halfwords. The first address is `cur_desc_i`, and each accepted request is followed by one 2 bytes higher.
- R5: Small-list and large-list modes read `size` halfwords starting at `next_ptr_i`.
- R6: In large-list mode the first halfword replaces bits [15:0] of the next-descriptor pointer and the second replaces bits [31:16]. In small-list mode only the first is used, and it replaces bits [15:0].
- R7: The remaining halfwords load, in order: start address [15:0], start address [31:16], config, X count, X modify, Y count, Y modify. Fields not fetched keep their seed values.
- R8: When the load ends, `cur_desc_o` equals the next-descriptor pointer and `cur_addr_o` equals the start address. `cur_x_o` and `cur_y_o` take the X and Y counts, and a count of zero gives 0xFFFF.
- R9: The element size comes from config bits [3:2] of the loaded config: 00 and 11 mean 1 byte, 01 means 2 bytes and 10 means 4 bytes. A loaded start address that is not a multiple of the element size sets `align_err_o` with the done pulse. The flag is cleared by the next start.
- R10: `rd_valid_o` stays high, with a stable `rd_addr_o`, until `rd_ready_i` accepts it. Each accepted request gets one response, and responses are consumed in order.
- R11: `done_o` is high for exactly one cycle. That cycle is the first one in which the updated current registers are visible. `busy_o` is high from the start edge until then.
- R12: A start pulse while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a descriptor load |
| cfg_i | input | 16 | Seed configuration word |
| next_ptr_i | input | 32 | Seed next-descriptor pointer |
| cur_desc_i | input | 32 | Current descriptor pointer, array fetch base |
| start_addr_i | input | 32 | Seed start address |
| x_count_i | input | 16 | Seed X count |
| x_mod_i | input | 16 | Seed X modify |
| y_count_i | input | 16 | Seed Y count |
| y_mod_i | input | 16 | Seed Y modify |
| rd_valid_o | output | 1 | Halfword read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | 32 | Byte address of the requested halfword |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 16 | Read data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse: registers updated |
| cfg_err_o | output | 1 | Illegal flow/size, block in error state |
| align_err_o | output | 1 | Start address misaligned to element size |
| cfg_o | output | 16 | Config parameter |
| next_ptr_o | output | 32 | Next-descriptor pointer parameter |
| start_addr_o | output | 32 | Start address parameter |
| x_count_o | output | 16 | X count parameter |
| x_mod_o | output | 16 | X modify parameter |
| y_count_o | output | 16 | Y count parameter |
| y_mod_o | output | 16 | Y modify parameter |
| cur_desc_o | output | 32 | Current descriptor pointer |
| cur_addr_o | output | 32 | Current address |
| cur_x_o | output | 16 | Current X counter |
| cur_y_o | output | 16 | Current Y counter |

## Verification
A corrupted request counter shows on `rd_addr_o` in the first cycle after the affected handshake, as a skipped or repeated address. It also shows in the number of requests counted before `done_o`. A wrong response counter or field decode puts a halfword in the wrong parameter, which becomes visible at the done pulse. A wrong state transition shows as a missing, doubled or early `done_o`, or as a read issued while `cfg_err_o` is high. The bench compares every parameter and current register at the done cycle against a model built from the memory contents, and records every accepted request address.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    parameter int AW       = 32;
    parameter int HW       = 16;
    parameter int MAX_DESC = 9;
    localparam int CW      = $clog2(MAX_DESC + 1);

    localparam int FLOW_LSB = 12;
    localparam int SIZE_LSB = 8;
    localparam int WSZ_LSB  = 2;

    localparam logic [2:0] FL_STOP  = 3'd0;
    localparam logic [2:0] FL_AUTO  = 3'd1;
    localparam logic [2:0] FL_ARRAY = 3'd4;
    localparam logic [2:0] FL_SMALL = 3'd6;
    localparam logic [2:0] FL_LARGE = 3'd7;

    localparam int ARRAY_MAX = 7;
    localparam int SMALL_MAX = 8;
    localparam int LARGE_MAX = MAX_DESC;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINAL, ST_ERR} st_e;

    typedef struct packed {
        logic [AW-1:0] ndp;
        logic [AW-1:0] sa;
        logic [HW-1:0] cfg;
        logic [HW-1:0] xc;
        logic [HW-1:0] xm;
        logic [HW-1:0] yc;
        logic [HW-1:0] ym;
    } par_t;

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] req;
        logic [CW-1:0] rsp;
        logic [CW-1:0] n;
        logic [1:0]    skip;
        logic [AW-1:0] base;
        par_t          par;
        logic [AW-1:0] cdp;
        logic [AW-1:0] ca;
        logic [HW-1:0] cx;
        logic [HW-1:0] cy;
        logic          done;
        logic          aerr;
    } seq_t;
endpackage

// File: rtl/dfs_decode.sv
module dfs_decode
    import dfs_pkg::*;
(
    input  logic [HW-1:0] cfg_i,
    output logic          legal_o,
    output logic [CW-1:0] n_o,
    output logic [1:0]    skip_o,
    output logic          from_cur_o
);
    logic [2:0]    flow;
    logic [CW-1:0] sz;

    assign flow = cfg_i[FLOW_LSB +: 3];
    assign sz   = cfg_i[SIZE_LSB +: CW];

    always_comb begin
        legal_o    = 1'b0;
        skip_o     = 2'd0;
        from_cur_o = 1'b0;
        n_o        = sz;
        case (flow)
            FL_STOP, FL_AUTO: legal_o = (sz == '0);
            FL_ARRAY: begin
                legal_o    = (sz >= CW'(1)) && (sz <= CW'(ARRAY_MAX));
                from_cur_o = 1'b1;
            end
            FL_SMALL: begin
                legal_o = (sz >= CW'(1)) && (sz <= CW'(SMALL_MAX));
                skip_o  = 2'd1;
            end
            FL_LARGE: begin
                legal_o = (sz >= CW'(1)) && (sz <= CW'(LARGE_MAX));
                skip_o  = 2'd2;
            end
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dfs_scatter.sv
module dfs_scatter
    import dfs_pkg::*;
(
    input  par_t          p_i,
    input  logic [CW-1:0] slot_i,
    input  logic [1:0]    skip_i,
    input  logic [HW-1:0] data_i,
    output par_t          p_o
);
    logic [CW-1:0] idx;

    assign idx = slot_i - CW'(skip_i);

    always_comb begin
        p_o = p_i;
        if (slot_i < CW'(skip_i)) begin
            if (slot_i == '0) p_o.ndp[HW-1:0]  = data_i;
            else              p_o.ndp[AW-1:HW] = data_i;
        end else begin
            case (idx)
                CW'(0):  p_o.sa[HW-1:0]  = data_i;
                CW'(1):  p_o.sa[AW-1:HW] = data_i;
                CW'(2):  p_o.cfg         = data_i;
                CW'(3):  p_o.xc          = data_i;
                CW'(4):  p_o.xm          = data_i;
                CW'(5):  p_o.yc          = data_i;
                CW'(6):  p_o.ym          = data_i;
                default: p_o             = p_i;
            endcase
        end
    end
endmodule

// File: rtl/dfs_finalize.sv
module dfs_finalize
    import dfs_pkg::*;
(
    input  par_t          p_i,
    output logic [AW-1:0] cdp_o,
    output logic [AW-1:0] ca_o,
    output logic [HW-1:0] cx_o,
    output logic [HW-1:0] cy_o,
    output logic          misalign_o
);
    logic [1:0] wsz;

    assign wsz   = p_i.cfg[WSZ_LSB +: 2];
    assign cdp_o = p_i.ndp;
    assign ca_o  = p_i.sa;
    assign cx_o  = (p_i.xc == '0) ? '1 : p_i.xc;
    assign cy_o  = (p_i.yc == '0) ? '1 : p_i.yc;

    always_comb begin
        case (wsz)
            2'b01:   misalign_o = p_i.sa[0];
            2'b10:   misalign_o = |p_i.sa[1:0];
            default: misalign_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
    import dfs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [15:0]   cfg_i,
    input  logic [31:0]   next_ptr_i,
    input  logic [31:0]   cur_desc_i,
    input  logic [31:0]   start_addr_i,
    input  logic [15:0]   x_count_i,
    input  logic [15:0]   x_mod_i,
    input  logic [15:0]   y_count_i,
    input  logic [15:0]   y_mod_i,
    output logic          rd_valid_o,
    input  logic          rd_ready_i,
    output logic [31:0]   rd_addr_o,
    input  logic          rsp_valid_i,
    input  logic [15:0]   rsp_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          cfg_err_o,
    output logic          align_err_o,
    output logic [15:0]   cfg_o,
    output logic [31:0]   next_ptr_o,
    output logic [31:0]   start_addr_o,
    output logic [15:0]   x_count_o,
    output logic [15:0]   x_mod_o,
    output logic [15:0]   y_count_o,
    output logic [15:0]   y_mod_o,
    output logic [31:0]   cur_desc_o,
    output logic [31:0]   cur_addr_o,
    output logic [15:0]   cur_x_o,
    output logic [15:0]   cur_y_o
);
    seq_t q, d;

    logic          dec_legal;
    logic [CW-1:0] dec_n;
    logic [1:0]    dec_skip;
    logic          dec_cur;
    par_t          par_scat;
    logic [AW-1:0] fin_cdp, fin_ca;
    logic [HW-1:0] fin_cx, fin_cy;
    logic          fin_mis;
    logic          req_fire;

    dfs_decode u_dec (
        .cfg_i      (cfg_i),
        .legal_o    (dec_legal),
        .n_o        (dec_n),
        .skip_o     (dec_skip),
        .from_cur_o (dec_cur)
    );

    dfs_scatter u_scat (
        .p_i    (q.par),
        .slot_i (q.rsp),
        .skip_i (q.skip),
        .data_i (rsp_data_i),
        .p_o    (par_scat)
    );

    dfs_finalize u_fin (
        .p_i        (q.par),
        .cdp_o      (fin_cdp),
        .ca_o       (fin_ca),
        .cx_o       (fin_cx),
        .cy_o       (fin_cy),
        .misalign_o (fin_mis)
    );

    assign rd_valid_o = (q.st == ST_FETCH) && (q.req < q.n);
    assign rd_addr_o  = q.base + AW'({q.req, 1'b0});
    assign req_fire   = rd_valid_o && rd_ready_i;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE, ST_ERR: begin
                if (start_i) begin
                    d.aerr = 1'b0;
                    if (!dec_legal) begin
                        d.st = ST_ERR;
                    end else begin
                        d.par  = '{ndp: next_ptr_i, sa: start_addr_i, cfg: cfg_i,
                                   xc: x_count_i, xm: x_mod_i, yc: y_count_i, ym: y_mod_i};
                        d.req  = '0;
                        d.rsp  = '0;
                        d.n    = dec_n;
                        d.skip = dec_skip;
                        d.base = dec_cur ? cur_desc_i : next_ptr_i;
                        d.st   = (dec_n == '0) ? ST_FINAL : ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (req_fire) d.req = q.req + CW'(1);
                if (rsp_valid_i) begin
                    d.par = par_scat;
                    d.rsp = q.rsp + CW'(1);
                    if (q.rsp == q.n - CW'(1)) d.st = ST_FINAL;
                end
            end
            ST_FINAL: begin
                d.cdp  = fin_cdp;
                d.ca   = fin_ca;
                d.cx   = fin_cx;
                d.cy   = fin_cy;
                d.aerr = fin_mis;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o       = (q.st == ST_FETCH) || (q.st == ST_FINAL);
    assign done_o       = q.done;
    assign cfg_err_o    = (q.st == ST_ERR);
    assign align_err_o  = q.aerr;
    assign cfg_o        = q.par.cfg;
    assign next_ptr_o   = q.par.ndp;
    assign start_addr_o = q.par.sa;
    assign x_count_o    = q.par.xc;
    assign x_mod_o      = q.par.xm;
    assign y_count_o    = q.par.yc;
    assign y_mod_o      = q.par.ym;
    assign cur_desc_o   = q.cdp;
    assign cur_addr_o   = q.ca;
    assign cur_x_o      = q.cx;
    assign cur_y_o      = q.cy;
endmodule

// File: rtl/desc_fetch_seq_chk.sv
module desc_fetch_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid_o,
    input logic        rd_ready_i,
    input logic [31:0] rd_addr_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        cfg_err_o,
    input logic [15:0] x_count_o,
    input logic [15:0] y_count_o,
    input logic [15:0] cur_x_o,
    input logic [15:0] cur_y_o,
    input logic [31:0] start_addr_o,
    input logic [31:0] cur_addr_o,
    input logic [31:0] next_ptr_o,
    input logic [31:0] cur_desc_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && rd_ready_i |=> !rd_valid_o || (rd_addr_o == $past(rd_addr_o) + 32'd2)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !rd_valid_o && !busy_o && !done_o); // R3

    AST_CUR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cur_addr_o == start_addr_o) && (cur_desc_o == next_ptr_o)); // R8

    AST_COUNT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cur_x_o == ((x_count_o == 16'd0) ? 16'hFFFF : x_count_o)) &&
                   (cur_y_o == ((y_count_o == 16'd0) ? 16'hFFFF : y_count_o))); // R8
endmodule

bind desc_fetch_seq desc_fetch_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .rd_addr_o    (rd_addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o),
    .x_count_o    (x_count_o),
    .y_count_o    (y_count_o),
    .cur_x_o      (cur_x_o),
    .cur_y_o      (cur_y_o),
    .start_addr_o (start_addr_o),
    .cur_addr_o   (cur_addr_o),
    .next_ptr_o   (next_ptr_o),
    .cur_desc_o   (cur_desc_o)
);

// File: tb/desc_fetch_seq_tb.sv
`timescale 1ns/1ps
module desc_fetch_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cfg_i = '0;
    logic [31:0] next_ptr_i = '0, cur_desc_i = '0, start_addr_i = '0;
    logic [15:0] x_count_i = '0, x_mod_i = '0, y_count_i = '0, y_mod_i = '0;
    logic        rd_valid_o, rd_ready_i, rsp_valid_i;
    logic [31:0] rd_addr_o;
    logic [15:0] rsp_data_i;
    logic        busy_o, done_o, cfg_err_o, align_err_o;
    logic [15:0] cfg_o, x_count_o, x_mod_o, y_count_o, y_mod_o, cur_x_o, cur_y_o;
    logic [31:0] next_ptr_o, start_addr_o, cur_desc_o, cur_addr_o;

    logic [15:0] mem [0:63];
    logic [31:0] addr_log [0:255];
    logic [7:0]  log_n = '0;
    logic [7:0]  ctr = '0;
    logic        stall_en = 1'b0;
    logic        rsp_v = 1'b0;
    logic [15:0] rsp_d = '0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    assign rd_ready_i  = !stall_en || ctr[0];
    assign rsp_valid_i = rsp_v;
    assign rsp_data_i  = rsp_d;

    always @(posedge clk) begin
        ctr <= ctr + 8'd1;
        if (!rst_n) begin
            rsp_v <= 1'b0;
        end else if (rd_valid_o && rd_ready_i) begin
            rsp_v <= 1'b1;
            rsp_d <= mem[rd_addr_o[6:1]];
            addr_log[log_n] <= rd_addr_o;
            log_n <= log_n + 8'd1;
        end else begin
            rsp_v <= 1'b0;
        end
    end

    desc_fetch_seq u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_load(input logic [15:0] cfg, input logic [31:0] ndp, cdp, sa,
                            input logic [15:0] xc, xm, yc, ym,
                            input bit stall, input bit interject, input string tag);
        logic [7:0]  base_n;
        logic [31:0] p_cdp, p_ca, e_ndp, e_sa, base;
        logic [15:0] p_cx, p_cy, e_cfg, e_xc, e_xm, e_yc, e_ym, v;
        logic [2:0]  flow;
        int n, skip, cyc;
        bit legal, e_mis;
        stall_en = stall;
        base_n = log_n;
        p_cdp = cur_desc_o; p_ca = cur_addr_o; p_cx = cur_x_o; p_cy = cur_y_o;
        @(negedge clk);
        cfg_i = cfg; next_ptr_i = ndp; cur_desc_i = cdp; start_addr_i = sa;
        x_count_i = xc; x_mod_i = xm; y_count_i = yc; y_mod_i = ym;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (interject) begin
            @(negedge clk);
            cfg_i = 16'h0000; start_addr_i = 32'h0000_0BAD; next_ptr_i = 32'h0000_0777;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && !cfg_err_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        flow = cfg[14:12]; n = int'(cfg[11:8]);
        skip = (flow == 3'd7) ? 2 : (flow == 3'd6) ? 1 : 0;
        case (flow)
            3'd0, 3'd1: legal = (n == 0);
            3'd4:       legal = (n >= 1 && n <= 7);
            3'd6:       legal = (n >= 1 && n <= 8);
            3'd7:       legal = (n >= 1 && n <= 9);
            default:    legal = 1'b0;
        endcase
        if (!legal) begin
            chk({tag, " R3 cfg_err"}, 32'(cfg_err_o), 32'd1);
            chk({tag, " R3 no reads"}, 32'(log_n - base_n), 32'd0);
            chk({tag, " R3 cur_addr kept"}, cur_addr_o, p_ca);
            chk({tag, " R3 cur_desc kept"}, cur_desc_o, p_cdp);
            chk({tag, " R3 cur counts kept"}, {cur_x_o, cur_y_o}, {p_cx, p_cy});
            repeat (3) @(negedge clk);
            chk({tag, " R3 error held, no done"}, {31'(cfg_err_o), done_o}, 32'd2);
            return;
        end
        chk({tag, " R11 done seen"}, 32'(done_o), 32'd1);
        base = (flow == 3'd4) ? cdp : ndp;
        e_ndp = ndp; e_sa = sa; e_cfg = cfg; e_xc = xc; e_xm = xm; e_yc = yc; e_ym = ym;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            a = base + 32'(2 * k);
            v = mem[a[6:1]];
            if (k - base_n < 0) v = v;
            chk({tag, " R4 R5 request address"}, addr_log[8'(base_n + 8'(k))], a);
            if (k < skip) begin
                if (k == 0) e_ndp[15:0] = v; else e_ndp[31:16] = v;
            end else begin
                case (k - skip)
                    0: e_sa[15:0] = v;
                    1: e_sa[31:16] = v;
                    2: e_cfg = v;
                    3: e_xc = v;
                    4: e_xm = v;
                    5: e_yc = v;
                    default: e_ym = v;
                endcase
            end
        end
        case (e_cfg[3:2])
            2'b01:   e_mis = e_sa[0];
            2'b10:   e_mis = |e_sa[1:0];
            default: e_mis = 1'b0;
        endcase
        chk({tag, " R2 R4 R5 read count"}, 32'(log_n - base_n), 32'(n));
        chk({tag, " R6 next pointer"}, next_ptr_o, e_ndp);
        chk({tag, " R7 start address"}, start_addr_o, e_sa);
        chk({tag, " R7 config"}, 32'(cfg_o), 32'(e_cfg));
        chk({tag, " R7 x count/modify"}, {x_count_o, x_mod_o}, {e_xc, e_xm});
        chk({tag, " R7 y count/modify"}, {y_count_o, y_mod_o}, {e_yc, e_ym});
        chk({tag, " R8 cur_desc"}, cur_desc_o, e_ndp);
        chk({tag, " R8 cur_addr"}, cur_addr_o, e_sa);
        chk({tag, " R8 cur_x"}, 32'(cur_x_o), 32'((e_xc == 0) ? 16'hFFFF : e_xc));
        chk({tag, " R8 cur_y"}, 32'(cur_y_o), 32'((e_yc == 0) ? 16'hFFFF : e_yc));
        chk({tag, " R9 align flag"}, 32'(align_err_o), 32'(e_mis));
        chk({tag, " R11 not busy at done"}, 32'(busy_o), 32'd0);
        @(negedge clk);
        chk({tag, " R11 done one cycle"}, 32'(done_o), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset controls", {28'd0, rd_valid_o, busy_o, done_o, cfg_err_o}, 32'd0);
        chk("R1 reset align", 32'(align_err_o), 32'd0);
        chk("R1 reset registers", cur_addr_o | cur_desc_o | next_ptr_o | start_addr_o, 32'd0);
    endtask

    task automatic t_stop_auto;
        run_load(16'h0004, 32'h0000_0050, 32'h0, 32'h0000_0101, 16'd0, 16'd2, 16'd5, 16'd2, 0, 0, "stop");
        run_load(16'h1008, 32'h0000_0060, 32'h0, 32'h0000_0204, 16'd9, 16'd4, 16'd0, 16'd4, 0, 0, "auto");
    endtask

    task automatic t_illegal;
        run_load(16'h0300, 32'h10, 32'h10, 32'h8, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "stop-size3");
        run_load(16'h2100, 32'h10, 32'h10, 32'h8, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "flow2");
        run_load(16'h4800, 32'h10, 32'h10, 32'h8, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "array-size8");
        run_load(16'h7A00, 32'h10, 32'h10, 32'h8, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "large-size10");
        run_load(16'h6000, 32'h10, 32'h10, 32'h8, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "small-size0");
    endtask

    task automatic t_array;
        run_load(16'h4700, 32'h0000_0010, 32'h0000_0020, 32'h0, 16'd3, 16'd1, 16'd3, 16'd1, 1, 0, "array7-stall");
        run_load(16'h4200, 32'h0000_0010, 32'h0000_0008, 32'h0000_0AB0, 16'd3, 16'd1, 16'd0, 16'd1, 0, 0, "array2");
    endtask

    task automatic t_lists;
        run_load(16'h6800, 32'h0000_0040, 32'h0, 32'h0, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "small8");
        run_load(16'h6100, 32'h0000_0030, 32'h0, 32'h0000_1111, 16'd7, 16'd1, 16'd7, 16'd1, 1, 0, "small1");
        run_load(16'h7900, 32'h0000_0046, 32'h0, 32'h0, 16'd1, 16'd1, 16'd1, 16'd1, 0, 0, "large9");
    endtask

    task automatic t_align;
        mem[6'h22] = 16'h0006;
        run_load(16'h7408, 32'h0000_0040, 32'h0, 32'h0, 16'd1, 16'd4, 16'd1, 16'd4, 0, 0, "R9 large4-misaligned");
        mem[6'h22] = 16'h0008;
        run_load(16'h7408, 32'h0000_0040, 32'h0, 32'h0, 16'd1, 16'd4, 16'd1, 16'd4, 0, 0, "R9 large4-aligned");
    endtask

    task automatic t_busy_start;
        run_load(16'h7900, 32'h0000_0000, 32'h0, 32'h0, 16'd2, 16'd1, 16'd2, 16'd1, 1, 1, "R12 start-while-busy");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h4000 + 16'(i * 16);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_auto();
        t_illegal();
        t_array();
        t_lists();
        t_align();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule